// File: doc/BRIEF.md
# Segmented DAC Pattern Playback Engine

This block feeds a fast current-steering DAC from a small on-chip pattern store. Software fills a 256-word memory of 6-bit samples through a plain write port and programs a pattern length. It then issues a start command. From then on the block walks the stored samples in address order and wraps at the programmed length, so any periodic sequence of up to 256 samples repeats without a seam. Typical contents are a pseudo-random sequence or one period of a test tone.

Each clock the engine delivers a group of 16 consecutive samples side by side. These are meant for a 16:1 serializer that sends lane 0 first. Before a sample leaves the block it is split into a segmented switch-control word. The four upper bits become a 15-line thermometer code that drives equal unary current cells. The two lower bits pass straight through to cells weighted one half and one quarter of a unary cell. Full scale is therefore 15.75 unary steps.

Top module: `dacpb_top`

## Requirements
- R1: While playback is stopped, a write with `mem_we` high stores `mem_wdata` at address `mem_addr` in the 256 x 6-bit sample memory.
- R2: Memory writes presented while playback is running are ignored, and the played pattern is unchanged.
- R3: `cfg_len_we` loads the pattern length from `cfg_len` only while playback is stopped; a value of 1..255 is the length, and 0 means 256. A length write while running is ignored.
- R4: In output group n, counted from 0 after a start, lane i carries the sample at address (16*n + i) mod L, where L is the effective length. Lane i occupies `out_therm[15*i +: 15]` and `out_lsb[2*i +: 2]`, and lane 0 is the first lane sent.
- R5: A start command is sampled at a clock edge E. After E, `playing` is high and `out_valid` is still low. After edge E+1, `out_valid` is high and the outputs carry group 0. A start while running restarts the sequence the same way: the group captured at E continues the old sequence, and group 0 follows at E+1.
- R6: A stop command sampled at edge E clears `playing` after E and clears `out_valid` after E+1. When start and stop are both high in the same cycle, stop wins.
- R7: For a sample whose upper four bits equal k, thermometer lines 0..k-1 of its lane are high and lines k..14 are low.
- R8: For each lane, `out_lsb` bit 1 equals sample bit 1 (the half-step cell) and `out_lsb` bit 0 equals sample bit 0 (the quarter-step cell).
- R9: While `playing` is low, `out_therm` and `out_lsb` hold their values.
- R10: After reset, `playing` and `out_valid` are low, `out_therm` and `out_lsb` are all zero, and the effective length is 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_we | input | 1 | Sample memory write strobe |
| mem_addr | input | 8 | Sample memory write address |
| mem_wdata | input | 6 | Sample value to store |
| cfg_len_we | input | 1 | Pattern length load strobe |
| cfg_len | input | 8 | Pattern length, 0 selects 256 |
| play_start | input | 1 | Start or restart playback |
| play_stop | input | 1 | Stop playback |
| playing | output | 1 | Playback running |
| out_valid | output | 1 | Output group valid |
| out_therm | output | 240 | Thermometer switch lines, 15 per lane |
| out_lsb | output | 32 | Binary switch lines, 2 per lane |

## Verification
Two register stages sit between a start command and its first group. A start sampled at edge E leaves the outputs invalid after E and presents group 0 after E+1; after that, one new group appears every edge. A stop clears `playing` one edge after it is sampled and `out_valid` one edge later still, and the outputs then freeze on the last captured group. The bench drives its inputs at falling edges and samples at the next falling edge. It keeps its own group counter, starting at 0 on the second sample after a start, and computes each expected group from its own memory model and the (16*n+i) mod L rule.

// File: rtl/dacpb_pkg.sv
package dacpb_pkg;
  parameter int SAMPLE_W = 6;
  parameter int LSB_W    = 2;
  parameter int MSB_W    = SAMPLE_W - LSB_W;
  parameter int THERM_W  = (1 << MSB_W) - 1;
  parameter int DEPTH    = 256;
  parameter int ADDR_W   = $clog2(DEPTH);
  parameter int LEN_W    = ADDR_W + 1;
  parameter int LANES    = 16;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [ADDR_W-1:0]   addr_t;
  typedef logic [LEN_W-1:0]    len_t;
  typedef logic [THERM_W-1:0]  therm_t;
  typedef logic [LSB_W-1:0]    lsb_t;
endpackage

// File: rtl/dacpb_ctrl.sv
module dacpb_ctrl
  import dacpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              play_start,
  input  logic              play_stop,
  input  logic              cfg_len_we,
  input  logic [ADDR_W-1:0] cfg_len,
  output logic              run_q,
  output logic              restart,
  output len_t              eff_len
);
  logic              run_d;
  logic [ADDR_W-1:0] len_q;
  logic [ADDR_W-1:0] len_d;
  logic              len_en;

  // stop has priority over start
  always_comb begin
    run_d = run_q;
    if (play_stop)       run_d = 1'b0;
    else if (play_start) run_d = 1'b1;
  end

  assign restart = play_start && !play_stop;

  // length is only loaded while stopped
  assign len_en = cfg_len_we && !run_q;
  assign len_d  = cfg_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  // zero selects the full depth
  always_comb begin
    if (len_q == '0) eff_len = len_t'(DEPTH);
    else             eff_len = {1'b0, len_q};
  end
endmodule

// File: rtl/dacpb_addr_gen.sv
module dacpb_addr_gen
  import dacpb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    advance,
  input  len_t                    eff_len,
  output logic [LANES*ADDR_W-1:0] lane_addr
);
  addr_t base_q;
  addr_t base_d;
  addr_t chain [LANES+1];

  function automatic addr_t wrap_inc(addr_t a, len_t len);
    len_t nxt;
    nxt = len_t'(a) + len_t'(1);
    if (nxt >= len) wrap_inc = '0;
    else            wrap_inc = nxt[ADDR_W-1:0];
  endfunction

  // ripple of lane addresses, each one step after the previous, wrapping at length
  always_comb begin
    chain[0] = base_q;
    for (int i = 0; i < LANES; i++) begin
      chain[i+1] = wrap_inc(chain[i], eff_len);
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane_addr
      assign lane_addr[g*ADDR_W +: ADDR_W] = chain[g];
    end
  endgenerate

  always_comb begin
    base_d = base_q;
    if (restart)      base_d = '0;
    else if (advance) base_d = chain[LANES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end
endmodule

// File: rtl/dacpb_mem.sv
module dacpb_mem
  import dacpb_pkg::*;
(
  input  logic                      clk,
  input  logic                      wr_en,
  input  addr_t                     wr_addr,
  input  sample_t                   wr_data,
  input  logic [LANES*ADDR_W-1:0]   rd_addr,
  output logic [LANES*SAMPLE_W-1:0] rd_data
);
  sample_t store [DEPTH];

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_rd_port
      assign rd_data[g*SAMPLE_W +: SAMPLE_W] = store[rd_addr[g*ADDR_W +: ADDR_W]];
    end
  endgenerate
endmodule

// File: rtl/dacpb_seg_enc.sv
module dacpb_seg_enc
  import dacpb_pkg::*;
(
  input  sample_t sample,
  output therm_t  therm,
  output lsb_t    lsb
);
  logic [MSB_W-1:0] msb;

  assign msb = sample[SAMPLE_W-1:LSB_W];
  assign lsb = sample[LSB_W-1:0];

  always_comb begin
    for (int j = 0; j < THERM_W; j++) begin
      therm[j] = (32'(msb) > j);
    end
  end
endmodule

// File: rtl/dacpb_top.sv
module dacpb_top
  import dacpb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mem_we,
  input  logic [ADDR_W-1:0]        mem_addr,
  input  logic [SAMPLE_W-1:0]      mem_wdata,
  input  logic                     cfg_len_we,
  input  logic [ADDR_W-1:0]        cfg_len,
  input  logic                     play_start,
  input  logic                     play_stop,
  output logic                     playing,
  output logic                     out_valid,
  output logic [LANES*THERM_W-1:0] out_therm,
  output logic [LANES*LSB_W-1:0]   out_lsb
);
  logic                      run_q;
  logic                      restart;
  len_t                      eff_len;
  logic [LANES*ADDR_W-1:0]   lane_addr;
  logic [LANES*SAMPLE_W-1:0] lane_sample;
  logic [LANES*THERM_W-1:0]  therm_d;
  logic [LANES*LSB_W-1:0]    lsb_d;
  logic                      wr_ok;
  logic                      out_en;

  dacpb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .play_start (play_start),
    .play_stop  (play_stop),
    .cfg_len_we (cfg_len_we),
    .cfg_len    (cfg_len),
    .run_q      (run_q),
    .restart    (restart),
    .eff_len    (eff_len)
  );

  dacpb_addr_gen u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .advance   (run_q),
    .eff_len   (eff_len),
    .lane_addr (lane_addr)
  );

  // writes are blocked during playback
  assign wr_ok = mem_we && !run_q;

  dacpb_mem u_mem (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_addr (mem_addr),
    .wr_data (mem_wdata),
    .rd_addr (lane_addr),
    .rd_data (lane_sample)
  );

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_enc
      dacpb_seg_enc u_enc (
        .sample (lane_sample[g*SAMPLE_W +: SAMPLE_W]),
        .therm  (therm_d[g*THERM_W +: THERM_W]),
        .lsb    (lsb_d[g*LSB_W +: LSB_W])
      );
    end
  endgenerate

  assign out_en = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_therm <= '0;
      out_lsb   <= '0;
    end else if (out_en) begin
      out_therm <= therm_d;
      out_lsb   <= lsb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= run_q;
  end

  assign playing = run_q;
endmodule

// File: rtl/dacpb_checker.sv
module dacpb_checker
  import dacpb_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     play_start,
  input logic                     play_stop,
  input logic                     playing,
  input logic                     out_valid,
  input logic [LANES*THERM_W-1:0] out_therm,
  input logic [LANES*LSB_W-1:0]   out_lsb
);
  p_start_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (play_start && !play_stop) |=> ##1 out_valid);

  p_start_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (play_start && !play_stop) |=> playing);

  p_valid_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(playing));

  p_stop_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    play_stop |=> (!playing ##1 !out_valid));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !playing |=> ($stable(out_therm) && $stable(out_lsb)));

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_shape
      p_therm_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_therm[g*THERM_W +: THERM_W] + THERM_W'(1)) &
          out_therm[g*THERM_W +: THERM_W]) == '0);
    end
  endgenerate
endmodule

bind dacpb_top dacpb_checker u_dacpb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .play_start (play_start),
  .play_stop  (play_stop),
  .playing    (playing),
  .out_valid  (out_valid),
  .out_therm  (out_therm),
  .out_lsb    (out_lsb)
);

// File: tb/tb_dacpb_top.sv
module tb_dacpb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         mem_we;
  logic [7:0]   mem_addr;
  logic [5:0]   mem_wdata;
  logic         cfg_len_we;
  logic [7:0]   cfg_len;
  logic         play_start;
  logic         play_stop;
  logic         playing;
  logic         out_valid;
  logic [239:0] out_therm;
  logic [31:0]  out_lsb;

  int nchk = 0;
  int nbad = 0;
  logic [5:0] model [256];
  int cur_len;

  always #5 clk = ~clk;

  dacpb_top dut (.*);

  task automatic chk(string req, logic [271:0] act, logic [271:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] enc_th(logic [5:0] s);
    logic [14:0] t;
    for (int j = 0; j < 15; j++) t[j] = (j < int'(s[5:2]));
    return t;
  endfunction

  function automatic logic [271:0] grp(int n);
    logic [271:0] v;
    v = '0;
    for (int i = 0; i < 16; i++) begin
      int a;
      a = (16*n + i) % cur_len;
      v[15*i +: 15]      = enc_th(model[a]);
      v[240 + 2*i +: 2]  = model[a][1:0];
    end
    return v;
  endfunction

  task automatic wr_mem(int a, logic [5:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_addr = 8'(a); mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic set_len(int v);
    @(negedge clk);
    cfg_len_we = 1'b1; cfg_len = 8'(v);
    @(negedge clk);
    cfg_len_we = 1'b0;
    cur_len = (v == 0) ? 256 : v;
  endtask

  // start, then check latency and `ncyc` groups; returns with group ncyc-1 shown
  task automatic start_play(int ncyc, string req);
    @(negedge clk);
    play_start = 1'b1;
    @(negedge clk);
    play_start = 1'b0;
    chk({"R5 first cycle ", req}, {270'd0, playing, out_valid}, {270'd0, 2'b10});
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk);
      chk({"R4 group ", req}, {out_lsb, out_therm}, grp(n));
      chk({"R5 valid ", req}, {271'd0, out_valid}, 272'd1);
    end
  endtask

  // stop after last shown group `last`; checks R6 and R9
  task automatic stop_play(int last);
    @(negedge clk);
    play_stop = 1'b1;
    @(negedge clk);
    play_stop = 1'b0;
    chk("R6 run low", {271'd0, playing}, 272'd0);
    chk("R6 valid one more", {271'd0, out_valid}, 272'd1);
    chk("R6 extra group", {out_lsb, out_therm}, grp(last + 2));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 valid low", {271'd0, out_valid}, 272'd0);
      chk("R9 hold", {out_lsb, out_therm}, grp(last + 2));
    end
  endtask

  initial begin
    #1500000;
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; mem_we = 0; mem_addr = 0; mem_wdata = 0;
    cfg_len_we = 0; cfg_len = 0; play_start = 0; play_stop = 0;
    cur_len = 256;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 flags", {270'd0, playing, out_valid}, 272'd0);
    chk("R10 outputs", {out_lsb, out_therm}, 272'd0);

    // R1 load whole memory, with directed corners
    for (int a = 0; a < 256; a++) begin
      model[a] = 6'($urandom);
      if (a == 0) model[a] = 6'd0;
      if (a == 1) model[a] = 6'd63;
      if (a == 2) model[a] = 6'b111100;
      if (a == 3) model[a] = 6'b000011;
      if (a == 4) model[a] = 6'b000110;
      wr_mem(a, model[a]);
    end

    // R10 default length 256, R7 R8 R4 across the wrap
    start_play(18, "R10 default len");
    stop_play(17);

    foreach (model[k]) begin end
    // lengths including non-multiples of 16 and edge values (R3 R4)
    set_len(16);  start_play(4, "R3 len16");  stop_play(3);
    set_len(5);   start_play(5, "R3 len5");   stop_play(4);
    set_len(1);   start_play(3, "R3 len1");   stop_play(2);
    set_len(37);  start_play(8, "R3 len37");  stop_play(7);
    set_len(255); start_play(34, "R3 len255"); stop_play(33);
    set_len(0);   start_play(17, "R3 len0 is 256"); stop_play(16);

    // random lengths
    for (int r = 0; r < 6; r++) begin
      set_len(1 + ($urandom % 255));
      start_play(6, "R4 random len");
      stop_play(5);
    end

    // R1 rewrite while stopped takes effect
    model[2] = 6'd21;
    wr_mem(2, model[2]);
    set_len(8);
    start_play(2, "R1 rewrite");

    // R2 write while running ignored; R3 length write while running ignored
    @(negedge clk);
    mem_we = 1'b1; mem_addr = 8'd3; mem_wdata = ~model[3];
    cfg_len_we = 1'b1; cfg_len = 8'd3;
    @(negedge clk);
    mem_we = 1'b0; cfg_len_we = 1'b0;
    // groups 2 and 3 shown at these two samples
    chk("R2 R3 during write", {out_lsb, out_therm}, grp(3));
    @(negedge clk);
    chk("R2 R3 after write", {out_lsb, out_therm}, grp(4));

    // R5 restart while running: group 5 then group 0
    @(negedge clk);
    play_start = 1'b1;
    chk("R5 pre restart", {out_lsb, out_therm}, grp(5));
    @(negedge clk);
    play_start = 1'b0;
    chk("R5 restart continues", {out_lsb, out_therm}, grp(6));
    @(negedge clk);
    chk("R5 restart group0", {out_lsb, out_therm}, grp(0));
    @(negedge clk);
    chk("R2 memory unchanged", {out_lsb, out_therm}, grp(1));
    stop_play(1);

    // R6 start and stop together: stop wins
    @(negedge clk);
    play_start = 1'b1; play_stop = 1'b1;
    @(negedge clk);
    play_start = 1'b0; play_stop = 1'b0;
    @(negedge clk);
    chk("R6 stop wins", {270'd0, playing, out_valid}, 272'd0);
    chk("R9 hold stop wins", {out_lsb, out_therm}, grp(3));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule